// File: doc/BRIEF.md
# Reset-Strapped Peripheral Window Router

This block sits between a processor's data request channel and two downstream targets: a dedicated peripheral port and the main system port. Each request carries an address, a write flag and write data. Requests that land in the peripheral address window go to the peripheral port when a routing enable is set. When the enable is clear, those requests go to the main system port. Every other address goes to the main system port, whatever the enable says.

The routing enable is a one-bit control register held inside the router. The processor reads and writes it at a fixed address, and accesses to that address never leave the block. When reset ends, the enable takes the level of an external strap input. After that, only software writes change it, and the strap is ignored. The router allows one transfer in flight at a time. The port choice is captured at the upstream handshake, so a change to the enable never redirects a transfer that has already been accepted.

Every request, read or write, completes with a one-cycle response pulse (`rvalid`) from the port it was sent to. Read data is valid during that pulse.

Top module: `pr_router_top`

## Requirements
- R1: An address from 0x40000000 to 0x5FFFFFFF inclusive is presented on `per_valid` when the enable is 1. `per_valid` and `sys_valid` are never high together.
- R2: An address in that window is presented on `sys_valid` when the enable is 0.
- R3: Any address outside the window, other than the control address, goes to `sys_valid` whatever the enable is. This includes 0x3FFFFFFF, 0x60000000 and 0xE000E004.
- R4: On the first clock edge after `rst_n` rises, the enable loads the level of `strap_per_en`. After that, changes on `strap_per_en` have no effect on the enable or on routing.
- R5: Address 0xE000E000 selects the control register, and such accesses are never forwarded downstream. A write to it stores bit 0 of `up_wdata` as the enable. A read from it returns the enable in bit 0 and zero in bits 31:1. Its response pulse comes one cycle after the handshake.
- R6: Only one request is outstanding at a time. After a handshake, `up_ready` stays low, and no downstream valid is raised, until the upstream response pulse has been seen.
- R7: The upstream response, `up_rvalid` and `up_rdata`, comes only from the port latched at the handshake. A response pulse from the other port while the transfer is pending is ignored.
- R8: While a request is being presented, `up_ready` equals the ready of the selected downstream port. For a control register access, `up_ready` is 1.
- R9: While `rst_n` is low, `per_valid`, `sys_valid` and `up_ready` are all low, even with `up_valid` high.
- R10: After a write to the control register, requests accepted later follow the new enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_per_en | input | 1 | Strap giving the enable value when reset ends |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_addr | input | 32 | Request address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | 32 | Write data |
| up_rvalid | output | 1 | Upstream response pulse |
| up_rdata | output | 32 | Read data, valid during `up_rvalid` |
| per_valid | output | 1 | Peripheral port request valid |
| per_ready | input | 1 | Peripheral port ready |
| per_addr | output | 32 | Peripheral port address |
| per_write | output | 1 | Peripheral port write flag |
| per_wdata | output | 32 | Peripheral port write data |
| per_rvalid | input | 1 | Peripheral port response pulse |
| per_rdata | input | 32 | Peripheral port read data |
| sys_valid | output | 1 | Main system port request valid |
| sys_ready | input | 1 | Main system port ready |
| sys_addr | output | 32 | Main system port address |
| sys_write | output | 1 | Main system port write flag |
| sys_wdata | output | 32 | Main system port write data |
| sys_rvalid | input | 1 | Main system port response pulse |
| sys_rdata | input | 32 | Main system port read data |

## Verification
Suppose the enable flop holds the wrong value, for example because the strap was sampled at the wrong edge or a write was decoded badly. The very next window request then raises the wrong downstream valid in the same cycle it is presented, and a control register read shows the bad bit one cycle after its handshake. Suppose instead the busy flag or the latched port is wrong. Then `up_ready` rises again before the response, or the response completes early on a stray pulse from the other port. The latency measured from handshake to `up_rvalid` exposes this within the same transfer. For this reason the bench compares routing on every presented cycle and measures the exact response latency of every transfer.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic [1:0] {
    RT_SYS  = 2'd0,
    RT_PER  = 2'd1,
    RT_CTRL = 2'd2
  } route_e;
endpackage

// File: rtl/pr_decode.sv
module pr_decode
  import pr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter logic [AW-1:0] WIN_LO  = 32'h4000_0000,
  parameter logic [AW-1:0] WIN_HI  = 32'h5FFF_FFFF,
  parameter logic [AW-1:0] CTRL_AD = 32'hE000_E000
) (
  input  logic [AW-1:0] addr,
  input  logic          per_en,
  output route_e        route
);
  logic in_win;
  logic is_ctrl;

  always_comb begin
    in_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
    is_ctrl = (addr == CTRL_AD);
    if (is_ctrl)              route = RT_CTRL;
    else if (in_win && per_en) route = RT_PER;
    else                      route = RT_SYS;
  end
endmodule

// File: rtl/pr_ctrl_reg.sv
module pr_ctrl_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          load_strap,
  input  logic          strap,
  input  logic          wr_en,
  input  logic          wr_bit,
  output logic          per_en,
  output logic [DW-1:0] rdata
);
  logic en_d;
  logic en_ce;

  always_comb begin
    en_ce = load_strap || wr_en;
    en_d  = load_strap ? strap : wr_bit;
  end

  always_ff @(posedge clk) begin
    if (en_ce) per_en <= en_d;
  end

  assign rdata = {{(DW-1){1'b0}}, per_en};
endmodule

// File: rtl/pr_router_top.sv
module pr_router_top
  import pr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter logic [AW-1:0] WIN_LO  = 32'h4000_0000,
  parameter logic [AW-1:0] WIN_HI  = 32'h5FFF_FFFF,
  parameter logic [AW-1:0] CTRL_AD = 32'hE000_E000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_per_en,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_addr,
  input  logic          up_write,
  input  logic [DW-1:0] up_wdata,
  output logic          up_rvalid,
  output logic [DW-1:0] up_rdata,
  output logic          per_valid,
  input  logic          per_ready,
  output logic [AW-1:0] per_addr,
  output logic          per_write,
  output logic [DW-1:0] per_wdata,
  input  logic          per_rvalid,
  input  logic [DW-1:0] per_rdata,
  output logic          sys_valid,
  input  logic          sys_ready,
  output logic [AW-1:0] sys_addr,
  output logic          sys_write,
  output logic [DW-1:0] sys_wdata,
  input  logic          sys_rvalid,
  input  logic [DW-1:0] sys_rdata
);
  logic          alive_q;
  logic          busy_q, busy_d;
  route_e        lat_q, lat_d;
  logic          lat_ce;
  route_e        cur_route;
  logic          per_en;
  logic [DW-1:0] ctrl_rdata;
  logic          can_issue;
  logic          hs;
  logic          ctrl_wr;

  pr_decode #(
    .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .CTRL_AD(CTRL_AD)
  ) u_dec (
    .addr   (up_addr),
    .per_en (per_en),
    .route  (cur_route)
  );

  pr_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk        (clk),
    .load_strap (!alive_q),
    .strap      (strap_per_en),
    .wr_en      (ctrl_wr),
    .wr_bit     (up_wdata[0]),
    .per_en     (per_en),
    .rdata      (ctrl_rdata)
  );

  // request side
  always_comb begin
    can_issue = alive_q && !busy_q && up_valid;
    per_valid = can_issue && (cur_route == RT_PER);
    sys_valid = can_issue && (cur_route == RT_SYS);
    unique case (cur_route)
      RT_PER:  up_ready = alive_q && !busy_q && per_ready;
      RT_CTRL: up_ready = alive_q && !busy_q;
      default: up_ready = alive_q && !busy_q && sys_ready;
    endcase
    hs      = up_valid && up_ready;
    ctrl_wr = hs && up_write && (cur_route == RT_CTRL);
  end

  assign per_addr  = up_addr;
  assign per_write = up_write;
  assign per_wdata = up_wdata;
  assign sys_addr  = up_addr;
  assign sys_write = up_write;
  assign sys_wdata = up_wdata;

  // response side
  always_comb begin
    unique case (lat_q)
      RT_PER:  begin up_rvalid = busy_q && per_rvalid; up_rdata = per_rdata;  end
      RT_CTRL: begin up_rvalid = busy_q;               up_rdata = ctrl_rdata; end
      default: begin up_rvalid = busy_q && sys_rvalid; up_rdata = sys_rdata;  end
    endcase
  end

  // next state
  always_comb begin
    lat_ce = hs;
    lat_d  = cur_route;
    busy_d = busy_q;
    if (hs)             busy_d = 1'b1;
    else if (up_rvalid) busy_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= 1'b0;
      busy_q  <= 1'b0;
      lat_q   <= RT_SYS;
    end else begin
      alive_q <= 1'b1;
      busy_q  <= busy_d;
      if (lat_ce) lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/pr_router_chk.sv
module pr_router_chk #(
  parameter int unsigned AW        = 32,
  parameter logic [AW-1:0] WIN_LO  = 32'h4000_0000,
  parameter logic [AW-1:0] WIN_HI  = 32'h5FFF_FFFF,
  parameter logic [AW-1:0] CTRL_AD = 32'hE000_E000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_ready,
  input logic [AW-1:0] up_addr,
  input logic          per_valid,
  input logic          per_ready,
  input logic          sys_valid,
  input logic          sys_ready
);
  // R9
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!per_valid && !sys_valid && !up_ready));

  // R1
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_valid, sys_valid}));

  // R3
  per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> ((up_addr >= WIN_LO) && (up_addr <= WIN_HI)));

  // R5
  ctrl_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid || sys_valid) |-> (up_addr != CTRL_AD));

  // R6
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (!up_ready && !per_valid && !sys_valid));

  // R8
  per_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> (up_ready == per_ready));

  // R8
  sys_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_valid |-> (up_ready == sys_ready));
endmodule

bind pr_router_top pr_router_chk #(
  .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .CTRL_AD(CTRL_AD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_valid  (up_valid),
  .up_ready  (up_ready),
  .up_addr   (up_addr),
  .per_valid (per_valid),
  .per_ready (per_ready),
  .sys_valid (sys_valid),
  .sys_ready (sys_ready)
);

// File: tb/pr_router_top_tb_top.sv
module pr_router_top_tb_top;
  localparam int PER_LAT = 1;
  localparam int SYS_LAT = 3;
  localparam logic [31:0] PER_TAG = 32'h5A5A_0000;
  localparam logic [31:0] SYS_TAG = 32'hA5A5_0000;
  localparam logic [31:0] CTRL_A  = 32'hE000_E000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_per_en;
  logic        up_valid, up_ready, up_write, up_rvalid;
  logic [31:0] up_addr, up_wdata, up_rdata;
  logic        per_valid, per_ready, per_write, per_rvalid;
  logic [31:0] per_addr, per_wdata, per_rdata;
  logic        sys_valid, sys_ready, sys_write, sys_rvalid;
  logic [31:0] sys_addr, sys_wdata, sys_rdata;
  logic        per_spur;

  int checks = 0;
  int errors = 0;
  int model_en = 0;
  bit presenting = 1'b0;
  bit in_txn = 1'b0;

  always #2.5 clk = ~clk;

  pr_router_top dut_i (
    .clk(clk), .rst_n(rst_n), .strap_per_en(strap_per_en),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_write(up_write), .up_wdata(up_wdata), .up_rvalid(up_rvalid),
    .up_rdata(up_rdata),
    .per_valid(per_valid), .per_ready(per_ready), .per_addr(per_addr),
    .per_write(per_write), .per_wdata(per_wdata), .per_rvalid(per_rvalid),
    .per_rdata(per_rdata),
    .sys_valid(sys_valid), .sys_ready(sys_ready), .sys_addr(sys_addr),
    .sys_write(sys_write), .sys_wdata(sys_wdata), .sys_rvalid(sys_rvalid),
    .sys_rdata(sys_rdata)
  );

  // downstream responders
  int per_cnt = 0;
  int sys_cnt = 0;
  logic [31:0] per_rd_q = '0;
  logic [31:0] sys_rd_q = '0;
  always @(posedge clk) begin
    if (per_valid && per_ready) begin
      per_cnt  <= PER_LAT;
      per_rd_q <= per_addr ^ PER_TAG;
    end else if (per_cnt != 0) per_cnt <= per_cnt - 1;
    if (sys_valid && sys_ready) begin
      sys_cnt  <= SYS_LAT;
      sys_rd_q <= sys_addr ^ SYS_TAG;
    end else if (sys_cnt != 0) sys_cnt <= sys_cnt - 1;
  end
  assign per_rvalid = (per_cnt == 1) || per_spur;
  assign sys_rvalid = (sys_cnt == 1);
  assign per_rdata  = per_rd_q;
  assign sys_rdata  = sys_rd_q;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  function automatic int exp_port(input logic [31:0] a);
    if (a == CTRL_A) return 2;
    if (a >= 32'h4000_0000 && a <= 32'h5FFF_FFFF && model_en != 0) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && presenting) begin
      check(per_valid == (exp_port(up_addr) == 1), "R1/R2/R3 per_valid route",
            {31'b0, per_valid}, {31'b0, exp_port(up_addr) == 1});
      check(sys_valid == (exp_port(up_addr) == 0), "R1/R2/R3 sys_valid route",
            {31'b0, sys_valid}, {31'b0, exp_port(up_addr) == 0});
    end
    if (rst_n && !presenting && !in_txn) begin
      check(!per_valid && !sys_valid && !up_rvalid, "R6 idle quiet",
            {29'b0, per_valid, sys_valid, up_rvalid}, 32'h0);
    end
  end

  // one request; stall = cycles with both downstream readies low
  task automatic xfer(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                      input int stall, input bit spur, input string req);
    int port;
    int lat;
    int n;
    logic [31:0] exp_rd;
    port = exp_port(a);
    lat  = (port == 1) ? PER_LAT : (port == 0) ? SYS_LAT : 1;
    @(negedge clk);
    up_addr = a; up_write = wr; up_wdata = wd; up_valid = 1'b1;
    per_ready = (stall == 0); sys_ready = (stall == 0);
    presenting = 1'b1;
    for (int s = 0; s < stall; s++) begin
      #1;
      if (port != 2)
        check(up_ready == 1'b0, {req, " R8 ready follows stalled port"},
              {31'b0, up_ready}, 32'h0);
      @(negedge clk);
    end
    per_ready = 1'b1; sys_ready = 1'b1;
    #1;
    check(up_ready == 1'b1, {req, " R8 ready follows port"}, {31'b0, up_ready}, 32'h1);
    @(posedge clk);
    in_txn = 1'b1;
    if (port == 2 && wr) model_en = int'(wd[0]);
    exp_rd = (port == 1) ? (a ^ PER_TAG) : (port == 0) ? (a ^ SYS_TAG) : {31'b0, model_en[0]};
    @(negedge clk);
    presenting = 1'b0;
    up_valid = 1'b0;
    up_addr = 32'h0;
    n = 1;
    #1;
    check(up_ready == 1'b0, {req, " R6 no accept while busy"}, {31'b0, up_ready}, 32'h0);
    if (spur) per_spur = 1'b1;
    while (!up_rvalid && n < 20) begin
      @(negedge clk);
      per_spur = 1'b0;
      n++;
    end
    per_spur = 1'b0;
    check(n == lat, {req, " R7 response latency from latched port"}, n, lat);
    if (!wr)
      check(up_rdata == exp_rd, {req, " R5/R7 read data"}, up_rdata, exp_rd);
    @(negedge clk);
    in_txn = 1'b0;
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst_n = 1'b0; strap_per_en = strap; up_valid = 1'b1; up_addr = 32'h4000_0000;
    repeat (3) @(negedge clk);
    check(!per_valid && !sys_valid && !up_ready, "R9 reset holds outputs low",
          {29'b0, per_valid, sys_valid, up_ready}, 32'h0);
    up_valid = 1'b0;
    rst_n = 1'b1;
    model_en = strap;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_per_en = 1'b1; up_valid = 1'b0; up_addr = '0;
    up_write = 1'b0; up_wdata = '0; per_ready = 1'b1; sys_ready = 1'b1;
    per_spur = 1'b0;

    // strap = 1
    do_reset(1'b1);
    xfer(CTRL_A, 1'b0, '0, 0, 1'b0, "R4 strap high read");
    strap_per_en = 1'b0;
    xfer(CTRL_A, 1'b0, '0, 0, 1'b0, "R4 strap ignored after reset");
    xfer(32'h4000_0000, 1'b0, '0, 0, 1'b0, "R1 window low edge");
    xfer(32'h5FFF_FFFF, 1'b0, '0, 0, 1'b0, "R1 window high edge");
    xfer(32'h3FFF_FFFF, 1'b0, '0, 0, 1'b0, "R3 below window");
    xfer(32'h6000_0000, 1'b0, '0, 0, 1'b0, "R3 above window");
    xfer(32'hE000_E004, 1'b0, '0, 0, 1'b0, "R3 next to control");
    xfer(32'h4800_0010, 1'b1, 32'hDEAD_BEEF, 2, 1'b0, "R8 peripheral stall");

    // strap = 0
    do_reset(1'b0);
    xfer(CTRL_A, 1'b0, '0, 0, 1'b0, "R4 strap low read");
    xfer(32'h4000_1234, 1'b0, '0, 3, 1'b0, "R2 window disabled stall");
    xfer(32'h4000_2000, 1'b0, '0, 0, 1'b1, "R7 stray peripheral pulse");
    xfer(CTRL_A, 1'b1, 32'hFFFF_FFFF, 0, 1'b0, "R5 write all ones");
    xfer(CTRL_A, 1'b0, '0, 0, 1'b0, "R5 read only bit 0");
    xfer(32'h5000_0000, 1'b0, '0, 0, 1'b0, "R10 route after enable");
    xfer(32'h7000_0000, 1'b0, '0, 0, 1'b0, "R3 outside window enabled");
    xfer(CTRL_A, 1'b1, 32'hFFFF_FFFE, 0, 1'b0, "R5 write bit0 clear");
    xfer(CTRL_A, 1'b0, '0, 0, 1'b0, "R5 read after clear");
    xfer(32'h5000_0000, 1'b0, '0, 0, 1'b0, "R10 route after disable");
    strap_per_en = 1'b1;
    xfer(32'h4000_0004, 1'b0, '0, 0, 1'b0, "R4 strap toggle no effect");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule